// File: doc/BRIEF.md
# Paired 8-bit Timer with Pulse Generation

This block holds two 8-bit up-counters, a compare register for each, and one prescaler that both counters share. A 2-bit mode input turns the pair into one of four machines: two separate interval timers, one timer 16 bits wide built by cascading the pair, a programmable pulse generator (PPG) driven by the first counter against both compare values, or a PWM whose period is a power of two. The PPG and PWM modes, and the match events of the timer modes, drive a single output flip-flop that feeds a pin.

Software-style control appears as plain level inputs and one-cycle write strobes. Each counter picks its count enable from four prescaler taps. The second counter can count the first counter's matches instead. The first compare register can be double buffered, so that a new duty value waits for the end of the running period. The output flip-flop can be forced low or high at any time.

Top module: `pair_timer8`

## Requirements
- R1: After reset, `irq0`, `irq1` and `tout` are 0, and both counters and both compare registers hold 0.
- R2: In mode 2'b00 with `run0` high, counter 0 counts on each of its ticks. When a tick finds the count equal to compare 0, the counter returns to 0 and `irq0` pulses on the next cycle. This gives an `irq0` period of (cmp0+1) ticks. Counter 1 behaves in the same way against compare 1 with `run1`, and drives `irq1`.
- R3: The prescaler has 9 bits and is held at 0 while `pre_run` is low. Clock select code 0 ticks every cycle. Codes 1, 2 and 3 tick once every 4, 32 and 512 cycles. With `pre_run` low no tick occurs.
- R4: In mode 2'b00, clock select code 0 on `src1` makes counter 1 tick on each counter 0 match. The `irq1` period is then (cmp0+1)·(cmp1+1) ticks of counter 0. Codes 1 to 3 on `src1` use the prescaler taps instead.
- R5: In mode 2'b01 the pair forms one 16-bit counter, with counter 1 as the upper byte. Counter 0 is not cleared by its own compare. Both counters clear when {cnt1,cnt0} equals {cmp1,cmp0}, and `irq1` then pulses. The period is 256·cmp1+cmp0+1 ticks. `irq0` never pulses in this mode.
- R6: In mode 2'b10, `tout` toggles when counter 0 matches compare 0 and again when it matches compare 1. Counter 0 clears on the compare 1 match. With cmp0 < cmp1 and `tout` starting at 0, `tout` is high for cmp1−cmp0 ticks and low for cmp0+1 ticks. `irq0` pulses on the first match and `irq1` on the second.
- R7: In mode 2'b11 only counter 0 runs, and it wraps after 2^n ticks. `pwm_len` 0 gives n=6, 1 gives n=7, and 2 or 3 gives n=8. `tout` goes high on the wrap, and `irq1` pulses there. `tout` goes low on a compare 0 match, and `irq0` pulses there. The high time is cmp0+1 ticks. A cmp0 of 2^n−1 or more keeps `tout` high.
- R8: With `dbuf_en` high, a write to compare 0 lands in a buffer. The buffer moves into compare 0 at the end of the running period of counter 0; in mode 2'b11 that is the 2^n wrap. With `dbuf_en` low, the write takes effect at once.
- R9: In mode 2'b00 with `tog_en` high, `tout` inverts on each match of counter 0 (`tog_sel`=0) or of counter 1 (`tog_sel`=1). This gives a square wave. In mode 2'b01 the 16-bit match inverts it.
- R10: `ff_clr` forces `tout` to 0 on the next cycle and overrides every other source. `ff_set` forces it to 1 unless `ff_clr` is also high.
- R11: A low run bit holds its counter at 0, and that counter raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 dual 8-bit, 01 16-bit, 10 PPG, 11 PWM |
| pre_run | input | 1 | Prescaler run |
| run0 | input | 1 | Counter 0 run |
| run1 | input | 1 | Counter 1 run |
| src0 | input | 2 | Counter 0 clock select (0:/1, 1:/4, 2:/32, 3:/512) |
| src1 | input | 2 | Counter 1 clock select (0: counter 0 match, else as src0) |
| pwm_len | input | 2 | PWM period length select |
| dbuf_en | input | 1 | Double buffer for compare 0 |
| wr0 | input | 1 | Write strobe, compare 0 |
| wr1 | input | 1 | Write strobe, compare 1 |
| wdata | input | 8 | Write data |
| tog_en | input | 1 | Invert output on match (modes 00/01) |
| tog_sel | input | 1 | Match source for inversion in mode 00 |
| ff_clr | input | 1 | Force output flip-flop to 0 |
| ff_set | input | 1 | Force output flip-flop to 1 |
| irq0 | output | 1 | Counter 0 match pulse |
| irq1 | output | 1 | Counter 1 / period match pulse |
| tout | output | 1 | Timer flip-flop output |

## Verification
A forced write to the flip-flop can arrive in the same cycle as a PWM wrap that would set `tout`. In the same way, a force-high can land on a match that would invert it. The bench provokes both by holding `ff_clr` across several PWM periods and `ff_set` across several toggle matches. Each cycle is then judged on whether `tout` kept the forced value every time. A second coincidence is a compare 0 write against the period end under double buffering. The bench judges it by sampling `tout` mid-period, where the old and new duty values disagree, and by measuring the following period.

// File: rtl/pair_timer8.sv
module pair_timer8 #(
  parameter int W    = 8,
  parameter int PW   = 9,
  parameter int TAP1 = 2,
  parameter int TAP2 = 5,
  parameter int TAP3 = PW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         pre_run,
  input  logic         run0,
  input  logic         run1,
  input  logic [1:0]   src0,
  input  logic [1:0]   src1,
  input  logic [1:0]   pwm_len,
  input  logic         dbuf_en,
  input  logic         wr0,
  input  logic         wr1,
  input  logic [W-1:0] wdata,
  input  logic         tog_en,
  input  logic         tog_sel,
  input  logic         ff_clr,
  input  logic         ff_set,
  output logic         irq0,
  output logic         irq1,
  output logic         tout
);
  localparam logic [W-1:0] MASK_S = W'((1 << (W-2)) - 1);
  localparam logic [W-1:0] MASK_M = W'((1 << (W-1)) - 1);
  localparam logic [W-1:0] MASK_L = '1;

  logic [PW-1:0] pre;
  logic [W-1:0]  cnt0, cnt1, cmp0, cmp1, buf0;
  logic [3:0]    taps;
  logic [W-1:0]  mask;
  logic          tick0, tick1, m0, m1, m1p, ovf, full, reload, ev0, ev1;

  wire md_dual = (mode == 2'b00);
  wire md_wide = (mode == 2'b01);
  wire md_ppg  = (mode == 2'b10);
  wire md_pwm  = (mode == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre <= '0;
    else if (!pre_run) pre <= '0;
    else               pre <= pre + 1'b1;

  assign taps = {pre_run & (&pre[TAP3-1:0]), pre_run & (&pre[TAP2-1:0]),
                 pre_run & (&pre[TAP1-1:0]), pre_run};

  assign mask = (pwm_len == 2'd0) ? MASK_S : (pwm_len == 2'd1) ? MASK_M : MASK_L;

  assign tick0 = run0 & taps[src0];
  assign m0    = tick0 && (cnt0 == cmp0);
  assign m1p   = tick0 && (cnt0 == cmp1);
  assign ovf   = tick0 && (cnt0 == mask);
  assign full  = m0 && (cnt1 == cmp1);
  assign tick1 = md_dual ? (run1 & ((src1 == 2'd0) ? m0 : taps[src1]))
               : md_wide ? (tick0 && (cnt0 == MASK_L)) : 1'b0;
  assign m1    = tick1 && (cnt1 == cmp1);

  assign reload = md_dual ? m0 : md_wide ? full : md_ppg ? m1p : ovf;
  assign ev0    = md_wide ? 1'b0 : md_pwm ? (m0 && !ovf) : m0;
  assign ev1    = md_dual ? m1 : reload;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt0 <= '0;
    else if (!run0) cnt0 <= '0;
    else if (tick0) cnt0 <= reload ? '0 : cnt0 + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt1 <= '0;
    else if (md_dual) begin
      if (!run1)      cnt1 <= '0;
      else if (tick1) cnt1 <= m1 ? '0 : cnt1 + 1'b1;
    end else if (md_wide) begin
      if (!run0 || full) cnt1 <= '0;
      else if (tick1)    cnt1 <= cnt1 + 1'b1;
    end else cnt1 <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp0 <= '0;
      cmp1 <= '0;
      buf0 <= '0;
    end else begin
      if (wr0) buf0 <= wdata;
      if (wr0 && !dbuf_en)       cmp0 <= wdata;
      else if (dbuf_en && reload) cmp0 <= buf0;
      if (wr1) cmp1 <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= ev0;
      irq1 <= ev1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      tout <= 1'b0;
    else if (ff_clr) tout <= 1'b0;
    else if (ff_set) tout <= 1'b1;
    else case (mode)
      2'b00:   if (tog_en && (tog_sel ? m1 : m0)) tout <= ~tout;
      2'b01:   if (tog_en && full) tout <= ~tout;
      2'b10:   if (m0 ^ m1p) tout <= ~tout;
      default: if (ovf) tout <= 1'b1; else if (m0) tout <= 1'b0;
    endcase

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clr |=> !tout); // R10
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_set && !ff_clr) |=> tout); // R10
  AST_NO_IRQ0_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    md_wide |=> !irq0); // R5
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run0 |=> (!irq0 && cnt0 == '0)); // R11
  AST_PWM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (md_pwm && ovf && !ff_clr) |=> (tout && irq1)); // R7
endmodule

// File: tb/sim_pair_timer8.sv
module sim_pair_timer8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 0, src0 = 0, src1 = 0, pwm_len = 0;
  logic pre_run = 0, run0 = 0, run1 = 0, dbuf_en = 0, wr0 = 0, wr1 = 0;
  logic tog_en = 0, tog_sel = 0, ff_clr = 0, ff_set = 0;
  logic [7:0] wdata = 0;
  logic irq0, irq1, tout;
  int errs = 0, checks = 0, n_irq0 = 0, n_irq1 = 0;

  always #10 clk = ~clk;

  pair_timer8 u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .pre_run(pre_run),
    .run0(run0), .run1(run1), .src0(src0), .src1(src1), .pwm_len(pwm_len),
    .dbuf_en(dbuf_en), .wr0(wr0), .wr1(wr1), .wdata(wdata), .tog_en(tog_en),
    .tog_sel(tog_sel), .ff_clr(ff_clr), .ff_set(ff_set), .irq0(irq0),
    .irq1(irq1), .tout(tout));

  always @(negedge clk) begin
    if (irq0) n_irq0++;
    if (irq1) n_irq1++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mode = 0; src0 = 0; src1 = 0; pwm_len = 0; pre_run = 0;
    run0 = 0; run1 = 0; dbuf_en = 0; wr0 = 0; wr1 = 0; tog_en = 0;
    tog_sel = 0; ff_clr = 0; ff_set = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wcmp(input bit which, input int v);
    @(negedge clk);
    wdata = 8'(v);
    if (which) wr1 = 1; else wr0 = 1;
    @(negedge clk);
    wr0 = 0; wr1 = 0;
  endtask

  task automatic period(input bit which, output int p);
    while (!(which ? irq1 : irq0)) @(negedge clk);
    p = 0;
    do begin @(negedge clk); p++; end while (!(which ? irq1 : irq0));
  endtask

  task automatic runlen(input bit lvl, output int n);
    while (tout == lvl) @(negedge clk);
    while (tout != lvl) @(negedge clk);
    n = 0;
    while (tout == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic pwm_high(input int n, output int h);
    while (!irq1) @(negedge clk);
    h = 0;
    repeat (1 << n) begin if (tout) h++; @(negedge clk); end
  endtask

  initial begin
    #3_800_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int p, h, a;
    do_reset();
    @(negedge clk);
    chk("R1 irq0", irq0, 0); chk("R1 irq1", irq1, 0); chk("R1 tout", tout, 0);

    // R2 sweep of compare 0, tick every cycle
    for (int c = 0; c < 16; c++) begin
      do_reset(); wcmp(0, c); pre_run = 1; run0 = 1;
      period(0, p); period(0, p);
      chk("R2 period", p, c + 1);
    end
    // R2 counter 1 independent
    do_reset(); wcmp(0, 6); wcmp(1, 2); src1 = 1; pre_run = 1; run0 = 1; run1 = 1;
    period(1, p); period(1, p); chk("R2 counter1", p, 12);

    // R3 taps
    for (int s = 1; s < 4; s++) begin
      do_reset(); wcmp(0, 1); src0 = 2'(s); pre_run = 1; run0 = 1;
      period(0, p); period(0, p);
      chk("R3 tap", p, 2 * (s == 1 ? 4 : s == 2 ? 32 : 512));
    end
    do_reset(); wcmp(0, 0); run0 = 1; a = n_irq0;
    repeat (200) @(negedge clk);
    chk("R3 prescaler stopped", n_irq0 - a, 0);

    // R4 cascade
    do_reset(); wcmp(0, 3); wcmp(1, 2); pre_run = 1; run0 = 1; run1 = 1;
    period(1, p); period(1, p); chk("R4 cascade", p, 12);
    do_reset(); wcmp(0, 1); wcmp(1, 4); src0 = 1; pre_run = 1; run0 = 1; run1 = 1;
    period(1, p); period(1, p); chk("R4 cascade tap", p, 2 * 5 * 4);

    // R5 16-bit
    do_reset(); mode = 2'b01; wcmp(0, 5); wcmp(1, 1); pre_run = 1; run0 = 1;
    a = n_irq0;
    period(1, p); period(1, p); chk("R5 period", p, 262);
    chk("R5 no irq0", n_irq0 - a, 0);
    do_reset(); mode = 2'b01; wcmp(0, 0); wcmp(1, 2); pre_run = 1; run0 = 1;
    period(1, p); period(1, p); chk("R5 period", p, 513);

    // R6 PPG
    for (int k = 0; k < 3; k++) begin
      int lo, hi;
      lo = (k == 0) ? 3 : (k == 1) ? 0 : 10;
      hi = (k == 0) ? 9 : (k == 1) ? 5 : 200;
      do_reset(); mode = 2'b10; wcmp(0, lo); wcmp(1, hi); pre_run = 1; run0 = 1;
      runlen(1, h); chk("R6 high", h, hi - lo);
      runlen(0, h); chk("R6 low", h, lo + 1);
      period(1, p); period(1, p); chk("R6 period", p, hi + 1);
    end

    // R7 PWM
    for (int k = 0; k < 5; k++) begin
      int c;
      c = (k == 0) ? 0 : (k == 1) ? 10 : (k == 2) ? 31 : (k == 3) ? 62 : 63;
      do_reset(); mode = 2'b11; wcmp(0, c); pre_run = 1; run0 = 1;
      pwm_high(6, h); pwm_high(6, h);
      chk("R7 n6 high", h, c + 1);
    end
    do_reset(); mode = 2'b11; pwm_len = 1; wcmp(0, 100); pre_run = 1; run0 = 1;
    pwm_high(7, h); pwm_high(7, h); chk("R7 n7 high", h, 101);
    period(1, p); chk("R7 n7 period", p, 128);
    do_reset(); mode = 2'b11; pwm_len = 2; wcmp(0, 200); pre_run = 1; run0 = 1;
    pwm_high(8, h); pwm_high(8, h); chk("R7 n8 high", h, 201);
    period(1, p); chk("R7 n8 period", p, 256);
    period(0, p); chk("R7 irq0 period", p, 256);

    // R8 double buffer
    do_reset(); mode = 2'b11; wcmp(0, 10); dbuf_en = 1; pre_run = 1; run0 = 1;
    pwm_high(6, h);
    while (!irq1) @(negedge clk);
    wdata = 30; wr0 = 1;
    @(negedge clk); wr0 = 0;
    repeat (18) @(negedge clk);
    chk("R8 old duty kept mid-period", tout, 0);
    pwm_high(6, h); chk("R8 new duty after wrap", h, 31);
    do_reset(); mode = 2'b11; wcmp(0, 10); pre_run = 1; run0 = 1;
    while (!irq1) @(negedge clk);
    wdata = 30; wr0 = 1;
    @(negedge clk); wr0 = 0;
    repeat (18) @(negedge clk);
    chk("R8 direct write immediate", tout, 1);

    // R9 square wave
    do_reset(); wcmp(0, 4); tog_en = 1; pre_run = 1; run0 = 1;
    runlen(1, h); chk("R9 high", h, 5);
    runlen(0, h); chk("R9 low", h, 5);
    do_reset(); wcmp(0, 4); wcmp(1, 1); tog_en = 1; tog_sel = 1;
    pre_run = 1; run0 = 1; run1 = 1;
    runlen(1, h); chk("R9 counter1 toggle", h, 10);

    // R10 forced values against coinciding events
    do_reset(); mode = 2'b11; wcmp(0, 31); pre_run = 1; run0 = 1;
    while (!irq1) @(negedge clk);
    ff_clr = 1; @(negedge clk);
    chk("R10 clear next cycle", tout, 0);
    a = 0;
    repeat (200) begin @(negedge clk); if (tout) a++; end
    chk("R10 clear holds over wraps", a, 0);
    ff_clr = 0;
    do_reset(); wcmp(0, 2); tog_en = 1; pre_run = 1; run0 = 1; ff_set = 1;
    @(negedge clk); a = 0;
    repeat (40) begin @(negedge clk); if (!tout) a++; end
    chk("R10 set holds over matches", a, 0);
    ff_clr = 1; @(negedge clk);
    chk("R10 clear beats set", tout, 0);

    // R11 run bit low
    do_reset(); wcmp(0, 0); wcmp(1, 0); pre_run = 1; a = n_irq0; p = n_irq1;
    repeat (100) @(negedge clk);
    chk("R11 no irq0", n_irq0 - a, 0);
    chk("R11 no irq1", n_irq1 - p, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule